// File: doc/BRIEF.md
# Link Voltage Protection Supervisor

This block sits beside the control-law datapath of a boost power-factor stage. It decides two things: which operating mode the converter is in, and whether the power switch may be driven. It receives three digitized codes with a strobe. The codes are the current that represents the output link voltage, the current that represents the rectified line, and a tracked peak of the rectified line. It also receives a one-millisecond tick. Every decision is registered on the clock edge that accepts a strobed sample or a tick.

The block runs four checks side by side:
- A startup/normal mode detector with hysteresis.
- An overvoltage trip with a hysteretic release.
- An open-loop detector that trips when the link code drops below the line code.
- An overload timer. It counts the milliseconds spent in startup mode inside a rolling quiet window and forces a long timed shutdown that ends by itself.

The gate enable is high only while none of the three stop conditions is present. Samples arrive as a valid-qualified stream that the block always accepts. There is no back-pressure and no ready pin, so a sample that is presented with the strobe high is consumed in that cycle.

Top module: `lvs_supervisor`

## Requirements
- R1: After reset, startup_mode is 1, gate_en is 1, and ovp_flag, open_loop_flag and olp_shutdown are 0.
- R2: A strobed sample whose link code is below floor(NOM_CODE*START_PCT/100) (116 by default) sets startup_mode. A code of exactly 116 leaves a cleared startup_mode cleared.
- R3: A strobed sample whose link code is at least NOM_CODE (129) clears startup_mode. A code of 128 keeps it set.
- R4: A strobed sample whose link code exceeds OVP_TRIP (136) sets ovp_flag and drops gate_en at the same edge. A code of exactly 136 does not trip.
- R5: Once tripped, ovp_flag clears only on a strobed link code below OVP_TRIP-OVP_HYS (134). A code of 134 keeps it set. Recovery needs no other action.
- R6: A strobed sample whose link code is below its line code sets open_loop_flag. Equal codes do not set it.
- R7: While open_loop_flag is set, it clears only on a strobed sample whose link code is at least the line code and strictly above the peak-of-line code.
- R8: Every ms tick taken while in startup mode and not shut down adds one to an overload count. The tick that brings the count past OLP_MS (the 113th by default) sets olp_shutdown and drops gate_en.
- R9: The overload count is cleared only after WIN_MS (200) consecutive ticks outside startup mode. After WIN_MS-1 such ticks, the count carries on from where it stopped.
- R10: olp_shutdown stays set for exactly SHUT_MS (2500) ticks and clears on the last of them. The overload count restarts from zero.
- R11: gate_en is 1 exactly when ovp_flag, open_loop_flag and olp_shutdown are all 0. Codes presented with samp_valid low change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_valid | input | 1 | Strobe qualifying the three codes; always accepted |
| fb_code | input | CODE_W | Link-voltage feedback current code |
| line_code | input | CODE_W | Rectified-line current code |
| line_pk_code | input | CODE_W | Tracked peak-of-line code |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| gate_en | output | 1 | Switching permitted |
| startup_mode | output | 1 | Converter in startup mode |
| ovp_flag | output | 1 | Overvoltage stop active |
| open_loop_flag | output | 1 | Open/shorted feedback stop active |
| olp_shutdown | output | 1 | Overload timed shutdown active |

## Verification
The assertions assume two things. First, ms_tick is a single-cycle pulse. Second, the codes matter only in cycles where samp_valid is high. The stimulus drives the codes and the strobe in separate cycles from ticks, and the bench model assumes this ordering. Random samples are drawn around the mode and overvoltage thresholds, with line and peak codes in the same range, so every hysteresis band gets crossed many times. Directed runs hit each boundary at one count on either side and step the millisecond counters through their exact lengths.

// File: rtl/lvs_pkg.sv
package lvs_pkg;
  typedef struct packed {
    logic startup;
    logic ovp;
    logic open_loop;
    logic shutdown;
  } lvs_flags_t;

  function automatic int pct_of(input int base, input int pct);
    return (base * pct) / 100;
  endfunction
endpackage

// File: rtl/lvs_mode_hyst.sv
module lvs_mode_hyst #(
  parameter int CODE_W    = 8,
  parameter int NOM_CODE  = 129,
  parameter int START_PCT = 90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [CODE_W-1:0] fb_code,
  output logic              startup_mode
);
  localparam int ENTER_I = lvs_pkg::pct_of(NOM_CODE, START_PCT);
  localparam logic [CODE_W-1:0] ENTER_C = ENTER_I[CODE_W-1:0];
  localparam logic [CODE_W-1:0] EXIT_C  = NOM_CODE[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) startup_mode <= 1'b1;
    else if (samp_valid) begin
      if (fb_code < ENTER_C)       startup_mode <= 1'b1;
      else if (fb_code >= EXIT_C)  startup_mode <= 1'b0;
    end
  end

  AST_MODE_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid && (fb_code < ENTER_C) |=> startup_mode); // R2
  AST_MODE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid && (fb_code >= EXIT_C) |=> !startup_mode); // R3
  AST_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_valid |=> $stable(startup_mode)); // R11
endmodule

// File: rtl/lvs_ovp.sv
module lvs_ovp #(
  parameter int CODE_W   = 8,
  parameter int OVP_TRIP = 136,
  parameter int OVP_HYS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [CODE_W-1:0] fb_code,
  output logic              ovp_flag
);
  localparam logic [CODE_W-1:0] TRIP_C = OVP_TRIP[CODE_W-1:0];
  localparam int REL_I = OVP_TRIP - OVP_HYS;
  localparam logic [CODE_W-1:0] REL_C = REL_I[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovp_flag <= 1'b0;
    else if (samp_valid) begin
      if (fb_code > TRIP_C)                 ovp_flag <= 1'b1;
      else if (ovp_flag && fb_code < REL_C) ovp_flag <= 1'b0;
    end
  end

  AST_OVP_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid && (fb_code > TRIP_C) |=> ovp_flag); // R4
  AST_OVP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_flag && (!samp_valid || fb_code >= REL_C) |=> ovp_flag); // R5
endmodule

// File: rtl/lvs_open_loop.sv
module lvs_open_loop #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CODE_W-1:0] line_code,
  input  logic [CODE_W-1:0] line_pk_code,
  output logic              open_loop_flag
);
  logic fb_low, fb_ok;
  assign fb_low = fb_code < line_code;
  assign fb_ok  = (fb_code >= line_code) && (fb_code > line_pk_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_loop_flag <= 1'b0;
    else if (samp_valid) begin
      if (fb_low)                       open_loop_flag <= 1'b1;
      else if (open_loop_flag && fb_ok) open_loop_flag <= 1'b0;
    end
  end

  AST_OL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid && (fb_code < line_code) |=> open_loop_flag); // R6
  AST_OL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    open_loop_flag && samp_valid && (fb_code <= line_pk_code) |=> open_loop_flag); // R7
endmodule

// File: rtl/lvs_olp_timer.sv
module lvs_olp_timer #(
  parameter int OLP_MS  = 112,
  parameter int WIN_MS  = 200,
  parameter int SHUT_MS = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic startup_mode,
  output logic olp_shutdown
);
  localparam int OLP_W = $clog2(OLP_MS + 2);
  localparam int WIN_W = $clog2(WIN_MS + 1);
  localparam int SC_W  = $clog2(SHUT_MS + 1);
  localparam logic [OLP_W-1:0] OLP_LAST = OLP_MS[OLP_W-1:0];
  localparam int WIN_LI = WIN_MS - 1;
  localparam int SC_LI  = SHUT_MS - 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_LI[WIN_W-1:0];
  localparam logic [SC_W-1:0]  SC_LAST  = SC_LI[SC_W-1:0];

  logic [OLP_W-1:0] olp_cnt;
  logic [WIN_W-1:0] win_cnt;
  logic [SC_W-1:0]  sc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      olp_shutdown <= 1'b0;
      olp_cnt      <= '0;
      win_cnt      <= '0;
      sc_cnt       <= '0;
    end else if (ms_tick) begin
      if (olp_shutdown) begin
        if (sc_cnt == SC_LAST) begin
          olp_shutdown <= 1'b0;
          sc_cnt       <= '0;
        end else begin
          sc_cnt <= sc_cnt + 1'b1;
        end
      end else if (startup_mode) begin
        win_cnt <= '0;
        if (olp_cnt == OLP_LAST) begin
          olp_shutdown <= 1'b1;
          olp_cnt      <= '0;
          sc_cnt       <= '0;
        end else begin
          olp_cnt <= olp_cnt + 1'b1;
        end
      end else begin
        if (win_cnt == WIN_LAST) begin
          win_cnt <= '0;
          olp_cnt <= '0;
        end else begin
          win_cnt <= win_cnt + 1'b1;
        end
      end
    end
  end

  AST_SHUT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick |=> $stable(olp_shutdown)); // R10
  AST_SHUT_NEEDS_STARTUP: assert property (@(posedge clk) disable iff (!rst_n)
    !olp_shutdown && !startup_mode |=> !olp_shutdown); // R8
  AST_OLP_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    olp_cnt <= OLP_LAST); // R8
endmodule

// File: rtl/lvs_supervisor.sv
module lvs_supervisor #(
  parameter int CODE_W    = 8,
  parameter int NOM_CODE  = 129,
  parameter int START_PCT = 90,
  parameter int OVP_TRIP  = 136,
  parameter int OVP_HYS   = 2,
  parameter int OLP_MS    = 112,
  parameter int WIN_MS    = 200,
  parameter int SHUT_MS   = 2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CODE_W-1:0] line_code,
  input  logic [CODE_W-1:0] line_pk_code,
  input  logic              ms_tick,
  output logic              gate_en,
  output logic              startup_mode,
  output logic              ovp_flag,
  output logic              open_loop_flag,
  output logic              olp_shutdown
);
  lvs_pkg::lvs_flags_t flags;

  lvs_mode_hyst #(.CODE_W(CODE_W), .NOM_CODE(NOM_CODE), .START_PCT(START_PCT)) u_mode (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .fb_code(fb_code),
    .startup_mode(flags.startup));

  lvs_ovp #(.CODE_W(CODE_W), .OVP_TRIP(OVP_TRIP), .OVP_HYS(OVP_HYS)) u_ovp (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .fb_code(fb_code),
    .ovp_flag(flags.ovp));

  lvs_open_loop #(.CODE_W(CODE_W)) u_ol (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .fb_code(fb_code),
    .line_code(line_code), .line_pk_code(line_pk_code),
    .open_loop_flag(flags.open_loop));

  lvs_olp_timer #(.OLP_MS(OLP_MS), .WIN_MS(WIN_MS), .SHUT_MS(SHUT_MS)) u_olp (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .startup_mode(flags.startup),
    .olp_shutdown(flags.shutdown));

  assign startup_mode   = flags.startup;
  assign ovp_flag       = flags.ovp;
  assign open_loop_flag = flags.open_loop;
  assign olp_shutdown   = flags.shutdown;
  assign gate_en        = !(flags.ovp || flags.open_loop || flags.shutdown);

  localparam logic [CODE_W-1:0] TRIP_C = OVP_TRIP[CODE_W-1:0];

  AST_GATE_OVP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid && (fb_code > TRIP_C) |=> !gate_en); // R4
  AST_GATE_OL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid && (fb_code < line_code) |=> !gate_en); // R11
endmodule

// File: tb/lvs_supervisor_tb.sv
module lvs_supervisor_tb;
  localparam int CLK_PER = 10;
  localparam int W = 8;
  localparam int OLP_MS = 112;
  localparam int WIN_MS = 200;
  localparam int SHUT_MS = 2500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic samp_valid = 1'b0;
  logic ms_tick = 1'b0;
  logic [W-1:0] fb_code = '0, line_code = '0, line_pk_code = '0;
  logic gate_en, startup_mode, ovp_flag, open_loop_flag, olp_shutdown;

  int total = 0;
  int bad = 0;

  // bench model state
  bit m_start, m_ovp, m_ol, m_shut;
  int m_olp, m_win, m_sc;

  always #(CLK_PER/2) clk = ~clk;

  lvs_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .fb_code(fb_code),
    .line_code(line_code), .line_pk_code(line_pk_code), .ms_tick(ms_tick),
    .gate_en(gate_en), .startup_mode(startup_mode), .ovp_flag(ovp_flag),
    .open_loop_flag(open_loop_flag), .olp_shutdown(olp_shutdown));

  function automatic logic [4:0] exp_vec();
    return {!(m_ovp || m_ol || m_shut), m_start, m_ovp, m_ol, m_shut};
  endfunction

  task automatic check(input string req);
    logic [4:0] act;
    act = {gate_en, startup_mode, ovp_flag, open_loop_flag, olp_shutdown};
    total++;
    if (act !== exp_vec()) begin
      bad++;
      $display("FAIL %s: {gate,start,ovp,ol,shut} actual=%b expected=%b at %0t",
               req, act, exp_vec(), $time);
    end
  endtask

  task automatic model_sample(input int fb, input int ln, input int pk);
    if (fb < 116) m_start = 1;            // R2
    else if (fb >= 129) m_start = 0;      // R3
    if (fb > 136) m_ovp = 1;              // R4
    else if (m_ovp && fb < 134) m_ovp = 0; // R5
    if (fb < ln) m_ol = 1;                // R6
    else if (m_ol && fb >= ln && fb > pk) m_ol = 0; // R7
  endtask

  task automatic model_tick();
    if (m_shut) begin
      m_sc++;
      if (m_sc >= SHUT_MS) begin m_shut = 0; m_sc = 0; end   // R10
    end else if (m_start) begin
      m_win = 0;
      m_olp++;
      if (m_olp > OLP_MS) begin m_shut = 1; m_olp = 0; m_sc = 0; end // R8
    end else begin
      m_win++;
      if (m_win >= WIN_MS) begin m_win = 0; m_olp = 0; end    // R9
    end
  endtask

  task automatic do_sample(input int fb, input int ln, input int pk, input string req);
    @(negedge clk);
    fb_code = W'(fb); line_code = W'(ln); line_pk_code = W'(pk);
    samp_valid = 1'b1;
    @(posedge clk);
    #(CLK_PER/4);
    samp_valid = 1'b0;
    model_sample(fb, ln, pk);
    check(req);
  endtask

  task automatic do_tick(input string req, input bit chk);
    @(negedge clk);
    ms_tick = 1'b1;
    @(posedge clk);
    #(CLK_PER/4);
    ms_tick = 1'b0;
    model_tick();
    if (chk) check(req);
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) do_tick(req, i == n - 1);
  endtask

  initial begin
    #(CLK_PER * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_start = 1; m_ovp = 0; m_ol = 0; m_shut = 0;
    m_olp = 0; m_win = 0; m_sc = 0;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // mode hysteresis
    do_sample(128, 10, 20, "R3 128 keeps startup");
    do_sample(129, 10, 20, "R3 129 exits startup");
    do_sample(116, 10, 20, "R2 116 stays normal");
    do_sample(115, 10, 20, "R2 115 enters startup");
    do_sample(130, 10, 20, "R3 back to normal");

    // overvoltage
    do_sample(136, 10, 20, "R4 136 no trip");
    do_sample(137, 10, 20, "R4 137 trips");
    do_sample(134, 10, 20, "R5 134 holds");
    do_sample(133, 10, 20, "R5 133 releases");

    // open loop
    do_sample(130, 130, 120, "R6 equal no trip");
    do_sample(130, 131, 120, "R6 fb below line");
    do_sample(131, 131, 131, "R7 not above peak");
    do_sample(132, 131, 133, "R7 below peak");
    do_sample(132, 131, 131, "R7 clears");

    // ignored codes without strobe
    @(negedge clk);
    fb_code = '0; line_code = 8'hff; line_pk_code = 8'hff;
    repeat (3) @(negedge clk);
    check("R11 no strobe no change");

    // overload trip and timed shutdown
    do_sample(100, 10, 20, "R2 startup for overload");
    ticks(OLP_MS, "R8 112 ticks no trip");
    ticks(1, "R8 113th tick trips");
    ticks(SHUT_MS - 1, "R10 still shut at 2499");
    ticks(1, "R10 released at 2500");

    // window keeps count across a short gap
    ticks(50, "R8 count 50");
    do_sample(129, 10, 20, "R3 leave startup");
    ticks(WIN_MS - 1, "R9 gap 199");
    do_sample(100, 10, 20, "R2 re-enter startup");
    ticks(OLP_MS - 50, "R9 total 112");
    ticks(1, "R9 carried count trips");
    ticks(SHUT_MS, "R10 released again");

    // full window clears count
    ticks(60, "R8 count 60");
    do_sample(129, 10, 20, "R3 leave startup");
    ticks(WIN_MS, "R9 full window");
    do_sample(100, 10, 20, "R2 startup");
    ticks(OLP_MS, "R9 cleared count no trip");
    do_sample(129, 10, 20, "R3 normal");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(3) == 0) do_tick("R8 random tick", 1'b1);
      else do_sample(int'($urandom_range(145, 105)), int'($urandom_range(140, 100)),
                     int'($urandom_range(140, 100)), "R11 random sample");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule